// File: doc/BRIEF.md
# Detector Overload Protection Monitor

This block guards a multi-channel detector against sustained overload. On every valid sample strobe it looks at all channel samples side by side. A channel is in overload while its 14-bit sample is below a programmed threshold. The detector signal is negative-going, so a low reading means excess light. Each channel keeps its own count of consecutive overloaded samples. When any channel stays overloaded for more valid samples than the programmed duration, the block latches an overload state. That state drops the bias-enable output and lights the overload indicator.

The latched state stays until software writes any value to the status register. The status register also reports the lowest-numbered channel that caused the trip. Monitoring does not depend on measurement or streaming being enabled. It needs only valid samples and the two enable bits. The block never turns the bias supply back on by itself. Clearing only removes its own inhibit, and an external controller restores the supply.

Top module: `bias_overload_guard`

## Requirements
- R1: After reset, bias_en is 1, ovl_led is 0, and the control, duration and status registers all read 0.
- R2: Monitoring is armed only when control bits 15 and 14 are both 1. With either bit at 0, no sample can cause a trip, and all persistence counts are held at zero.
- R3: A channel sample qualifies as overloaded when it is strictly less than control bits 13:0, compared as unsigned numbers. A sample equal to the threshold does not qualify.
- R4: A trip occurs on the valid sample that makes a channel's run of consecutive qualifying valid samples longer than the duration register. With duration D, that is the (D+1)-th sample of the run. One non-qualifying valid sample restarts the run. Cycles with smp_valid low leave the run unchanged.
- R5: A trip is visible the cycle after the sample that caused it. At that point bias_en is 0, ovl_led is 1 and status bit 15 is 1. The state stays latched while no clear write occurs.
- R6: A write of any data to address 2 (status) clears the latched state. This sets bias_en to 1 and status to 0, unless R7 applies.
- R7: When a status clear write and a new trip happen in the same cycle, the trip wins and the state stays latched.
- R8: Status bits CHW-1:0 (2:0 for eight channels) hold the lowest channel index tripping in the cycle that set the latch, or that re-set it during a clear. Later trips do not change this field while the state is latched.
- R9: reg_rdata returns the control register at address 0 and the 16-bit duration register at address 1. At address 2 it returns the status, with bit 15 as the latch, the channel in the low bits, and other bits 0. Address 3 reads 0.
- R10: ovl_led is always the inverse of bias_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | All channel samples are valid this cycle |
| smp_data | input | NCH*14 | Channel samples, with channel k in bits 14k+13:14k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| bias_en | output | 1 | Detector bias permitted, low while an overload is latched |
| ovl_led | output | 1 | Overload indicator |

## Verification
The assertions check on every cycle the properties that hold as state relations. These are: the indicator is the inverse of bias enable; the block never trips while disarmed; a latch holds without a clear; a clear with no detection releases the latch; a simultaneous detection beats the clear; the reported channel stays frozen while latched. Only the bench scenarios can show the behaviour that depends on sample history or on values. This covers the exact sample on which a run exceeds the duration, a run restarting after one good sample, gaps with no valid sample, the strict threshold comparison, choosing the lowest channel among simultaneous trips, and the register readback.

// File: rtl/bias_overload_guard.sv
module bias_overload_guard #(
  parameter int NCH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [NCH*14-1:0]   smp_data,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  output logic                bias_en,
  output logic                ovl_led
);
  localparam int SW    = 14;
  localparam int CW    = 16;
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [15:0]    ctrl_q;
  logic [CW-1:0]  dur_q;
  logic           trip_q;
  logic [CHW-1:0] ch_q;
  logic [NCH-1:0] hit;
  logic [CHW-1:0] first;

  wire          armed = &ctrl_q[15:14];
  wire [SW-1:0] thr   = ctrl_q[SW-1:0];
  wire          clr   = reg_wr && (reg_addr == 2'd2);
  wire          any_hit = |hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] cnt;
    wire  [SW-1:0] s   = smp_data[g*SW +: SW];
    wire           low = armed && (s < thr);

    always_ff @(posedge clk) begin
      if (!rst_n || !armed)
        cnt <= '0;
      else if (smp_valid)
        cnt <= !low ? '0 : (cnt == CMAX) ? cnt : cnt + 1'b1;
    end

    assign hit[g] = smp_valid && low && (cnt >= dur_q);
  end

  always_comb begin
    first = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (hit[i]) first = CHW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dur_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) ctrl_q <= reg_wdata;
      if (reg_addr == 2'd1) dur_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      ch_q   <= '0;
    end else if (any_hit) begin
      trip_q <= 1'b1;
      if (!trip_q || clr) ch_q <= first;
    end else if (clr) begin
      trip_q <= 1'b0;
      ch_q   <= '0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = dur_q;
      2'd2:    reg_rdata = {trip_q, {(15-CHW){1'b0}}, ch_q};
      default: reg_rdata = '0;
    endcase
  end

  assign bias_en = !trip_q;
  assign ovl_led = trip_q;

  p_led_inv_bias_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_led != bias_en);
  p_no_trip_disarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !trip_q) |=> !trip_q);
  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr) |=> trip_q);
  p_clear_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_hit) |=> (bias_en && reg_rdata[15] == 1'b0 || reg_addr != 2'd2) && !trip_q);
  p_trip_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && any_hit) |=> trip_q);
  p_channel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr) |=> $stable(ch_q));
endmodule

// File: tb/test_bias_overload_guard.sv
module test_bias_overload_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam logic [13:0] HI = 14'h3FFF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [NCH*14-1:0] smp_data = '1;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              bias_en, ovl_led;

  int checks = 0;
  int fails  = 0;

  bias_overload_guard #(.NCH(NCH)) i_bias_overload_guard (
    .clk, .rst_n, .smp_valid, .smp_data, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .bias_en, .ovl_led
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic [NCH*14-1:0] vec(input int a, input int b, input logic [13:0] v);
    logic [NCH*14-1:0] d = '1;
    for (int k = 0; k < NCH; k++)
      if (k == a || k == b) d[k*14 +: 14] = v;
    return d;
  endfunction

  task automatic smp(input logic [NCH*14-1:0] d);
    smp_data = d; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; smp_data = '1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic out(input string req, input logic tripped);
    chk({req, " bias_en"}, {15'd0, bias_en}, {15'd0, !tripped});
    chk({req, " ovl_led"}, {15'd0, ovl_led}, {15'd0, tripped});
  endtask

  task automatic t_reset();
    out("R1 reset", 1'b0);
    rd("R1 ctrl", 2'd0, 16'h0000);
    rd("R1 dur", 2'd1, 16'h0000);
    rd("R1 status", 2'd2, 16'h0000);
  endtask

  task automatic t_regs();
    wr(2'd0, 16'hC100);
    wr(2'd1, 16'h1234);
    rd("R9 ctrl", 2'd0, 16'hC100);
    rd("R9 dur", 2'd1, 16'h1234);
    rd("R9 addr3", 2'd3, 16'h0000);
    rd("R9 status idle", 2'd2, 16'h0000);
  endtask

  task automatic t_disarmed();
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h4100);
    repeat (3) smp(vec(2, -1, 14'h0));
    out("R2 only bit14", 1'b0);
    wr(2'd0, 16'h8100);
    repeat (3) smp(vec(2, -1, 14'h0));
    out("R2 only bit15", 1'b0);
    rd("R2 status", 2'd2, 16'h0000);
  endtask

  task automatic t_threshold();
    wr(2'd0, 16'hC100);
    wr(2'd1, 16'd0);
    smp(vec(1, -1, 14'h100));
    out("R3 equal not overload", 1'b0);
    smp(vec(1, -1, 14'h0FF));
    out("R3 below trips", 1'b1);
    rd("R5 status after trip", 2'd2, 16'h8001);
    smp(vec(1, -1, HI));
    out("R5 latched", 1'b1);
    wr(2'd2, 16'h1234);
    out("R6 cleared", 1'b0);
    rd("R6 status cleared", 2'd2, 16'h0000);
  endtask

  task automatic t_duration();
    wr(2'd1, 16'd3);
    repeat (3) smp(vec(5, -1, 14'h010));
    out("R4 three of four", 1'b0);
    repeat (2) @(negedge clk);
    smp(vec(5, -1, 14'h010));
    out("R4 fourth after gap", 1'b1);
    rd("R4 status ch5", 2'd2, 16'h8005);
    smp(vec(5, -1, HI));
    wr(2'd2, 16'h0000);
    out("R6 clear any value", 1'b0);
    repeat (3) smp(vec(5, -1, 14'h010));
    smp(vec(5, -1, 14'h100));
    repeat (3) smp(vec(5, -1, 14'h010));
    out("R4 run restarted", 1'b0);
    smp(vec(5, -1, 14'h010));
    out("R4 restarted run trips", 1'b1);
    smp(vec(5, -1, HI));
    wr(2'd2, 16'hFFFF);
    out("R6 clear after run", 1'b0);
  endtask

  task automatic t_race();
    wr(2'd1, 16'd0);
    smp(vec(3, -1, 14'h000));
    out("R7 setup trip", 1'b1);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h5555;
    smp_data = vec(3, -1, 14'h000); smp_valid = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; smp_valid = 1'b0; smp_data = '1;
    out("R7 detection wins", 1'b1);
    rd("R7 status", 2'd2, 16'h8003);
    smp(vec(3, -1, HI));
    wr(2'd2, 16'h0001);
    out("R7 later clear", 1'b0);
  endtask

  task automatic t_first_channel();
    smp(vec(4, 6, 14'h000));
    rd("R8 lowest of two", 2'd2, 16'h8004);
    smp(vec(2, -1, 14'h000));
    rd("R8 not overwritten", 2'd2, 16'h8004);
    out("R8 still latched", 1'b1);
    smp('1);
    wr(2'd2, 16'h0000);
    rd("R8 cleared", 2'd2, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disarmed();
    t_threshold();
    t_duration();
    t_race();
    t_first_channel();
    summary();
    $finish;
  end
endmodule